// File: doc/BRIEF.md
# Divergence Reconvergence Stack

This block keeps track of which lanes of a single SIMD thread group are active while the group runs through branches. The lanes share one program counter. Each stack entry holds three things: a next PC, a per-lane active mask, and an optional reconvergence PC. The issue logic always fetches from the top entry's next PC and enables the lanes in the top entry's mask.

A branch result arrives in one cycle. It carries a taken-lane mask, a taken target, a fall-through target and the reconvergence PC computed for that branch.

- If the active lanes split between the two paths, the top entry is retargeted to the reconvergence PC. One entry is then pushed for each path, and the taken path sits on top.
- If all active lanes go the same way, no entry is pushed and only the top entry's next PC changes.

When the top entry's next PC reaches its own reconvergence PC, the entry is popped. While that pop is pending, the block withdraws `ready_o` and ignores issue and branch inputs. The lanes beneath then resume.

A launch input, or reset, reloads the stack with a single full-mask entry that has no reconvergence PC.

Top module: `reconv_stack`

## Requirements
- R1: Reset or `launch_i` leaves exactly one entry, so `depth_o` = 1. That entry has an all-ones mask and no reconvergence PC. Its next PC is `RESET_PC` after reset and `launch_pc_i` after launch. Both also clear `overflow_o` and raise `ready_o` on the next cycle.
- R2: `pc_o` and `mask_o` always equal the next PC and mask of the top entry.
- R3: A divergent branch that finds `depth_o` > `DEPTH`-2 pushes nothing and leaves the stack unchanged. It sets `overflow_o`, which stays set until reset or launch.
- R4: A branch is divergent when the effective taken mask (`br_taken_mask_i` AND `mask_o`) is neither zero nor equal to `mask_o`. A divergent branch with room does the following on the next cycle:
  - it sets the old top's next PC to `br_reconv_pc_i`;
  - it pushes a fall-through entry with mask `mask_o` AND NOT taken and PC `br_fall_pc_i`;
  - it then pushes a taken entry on top with the effective taken mask and PC `br_target_pc_i`;
  - both new entries carry `br_reconv_pc_i`, and `depth_o` rises by 2.
- R5: A non-divergent branch leaves `depth_o` unchanged. If the effective taken mask equals `mask_o`, the top next PC becomes `br_target_pc_i`; if it is zero, the top next PC becomes `br_fall_pc_i`.
- R6: With `ready_o` high, `issue_adv_i` high and no branch, the top entry's next PC advances by one (modulo 2^`PC_W`) on the next cycle.
- R7: When the top entry has a reconvergence PC equal to its next PC, `ready_o` is low. The next cycle pops that entry, so `depth_o` falls by 1, and issue and branch inputs in that cycle have no effect. Pops chain one per cycle.
- R8: Taken-mask bits for lanes outside `mask_o` are ignored, and the base entry is never popped, so `depth_o` stays between 1 and `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_i | input | 1 | Start a kernel: reload a single full-mask entry |
| launch_pc_i | input | PC_W | Kernel entry PC used on launch |
| issue_adv_i | input | 1 | A non-branch instruction was issued this cycle |
| br_valid_i | input | 1 | A branch result is presented this cycle |
| br_taken_mask_i | input | LANES | Lanes that take the branch |
| br_target_pc_i | input | PC_W | Taken target PC |
| br_fall_pc_i | input | PC_W | Fall-through PC |
| br_reconv_pc_i | input | PC_W | Reconvergence PC for this branch |
| pc_o | output | PC_W | Fetch PC from the top entry |
| mask_o | output | LANES | Active-lane mask from the top entry |
| ready_o | output | 1 | Low while a pop is pending; inputs are ignored then |
| depth_o | output | $clog2(DEPTH+1) | Number of stack entries |
| overflow_o | output | 1 | Sticky flag for a divergent branch that found the stack full |

## Verification
The assertions check on every cycle that:
- the depth moves only by +2 on a divergent branch with room, by -1 on a pending pop, or not at all, and stays within its bounds;
- the PC advances by one on issue and follows the target or fall-through on a uniform branch;
- overflow is sticky and freezes the stack.

Only the bench scenarios can show the order of the pushed paths, how the fall-through mask beneath the taken path resumes, chained pops when a pushed path already sits at its reconvergence point, and the full-mask restore at the end of nesting.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    // Operation applied to the entry storage in one cycle.
    typedef enum logic [2:0] {
        STK_HOLD,
        STK_INIT,
        STK_POP,
        STK_RETARGET,
        STK_SPLIT
    } stk_op_e;

    // Number of bits to count 0..depth entries.
    function automatic int unsigned count_width(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/rstk_branch_eval.sv
module rstk_branch_eval #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] cur_mask_i,
    input  logic [LANES-1:0] taken_mask_i,
    output logic [LANES-1:0] taken_eff_o,
    output logic [LANES-1:0] fall_eff_o,
    output logic             diverge_o,
    output logic             all_taken_o
);
    // Lanes outside the current mask take no part in the branch.
    assign taken_eff_o = taken_mask_i & cur_mask_i;
    assign fall_eff_o  = cur_mask_i & ~taken_mask_i;
    assign diverge_o   = (|taken_eff_o) && (|fall_eff_o);
    assign all_taken_o = (|taken_eff_o) && !(|fall_eff_o);
endmodule

// File: rtl/rstk_store.sv
module rstk_store import rstk_pkg::*; #(
    parameter int  DEPTH   = 8,
    parameter int  CNT_W   = 4,
    parameter type ENTRY_T = logic
) (
    input  logic             clk,
    input  stk_op_e          op_i,
    input  ENTRY_T           init_ent_i,
    input  ENTRY_T           top_new_i,
    input  ENTRY_T           push_lo_i,
    input  ENTRY_T           push_hi_i,
    output ENTRY_T           top_o,
    output logic [CNT_W-1:0] count_o
);
    ENTRY_T           mem [DEPTH];
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] top_idx;
    logic [CNT_W-1:0] next_idx;

    assign top_idx  = count_q - CNT_W'(1);
    assign next_idx = count_q + CNT_W'(1);
    assign count_o  = count_q;

    always_ff @(posedge clk) begin
        unique case (op_i)
            STK_INIT:  count_q <= CNT_W'(1);
            STK_POP:   count_q <= top_idx;
            STK_SPLIT: count_q <= count_q + CNT_W'(2);
            default:   count_q <= count_q;
        endcase
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (op_i == STK_INIT) begin
                if (i == 0) begin
                    mem[i] <= init_ent_i;
                end
            end else if ((op_i == STK_RETARGET || op_i == STK_SPLIT) &&
                         top_idx == CNT_W'(i)) begin
                mem[i] <= top_new_i;
            end else if (op_i == STK_SPLIT && count_q == CNT_W'(i)) begin
                mem[i] <= push_lo_i;
            end else if (op_i == STK_SPLIT && next_idx == CNT_W'(i)) begin
                mem[i] <= push_hi_i;
            end
        end
    end

    always_comb begin
        top_o = mem[0];
        for (int i = 0; i < DEPTH; i++) begin
            if (top_idx == CNT_W'(i)) begin
                top_o = mem[i];
            end
        end
    end
endmodule

// File: rtl/reconv_stack.sv
module reconv_stack import rstk_pkg::*; #(
    parameter int              LANES    = 4,
    parameter int              PC_W     = 16,
    parameter int              DEPTH    = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    localparam int             CNT_W    = count_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch_i,
    input  logic [PC_W-1:0]  launch_pc_i,
    input  logic             issue_adv_i,
    input  logic             br_valid_i,
    input  logic [LANES-1:0] br_taken_mask_i,
    input  logic [PC_W-1:0]  br_target_pc_i,
    input  logic [PC_W-1:0]  br_fall_pc_i,
    input  logic [PC_W-1:0]  br_reconv_pc_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [LANES-1:0] mask_o,
    output logic             ready_o,
    output logic [CNT_W-1:0] depth_o,
    output logic             overflow_o
);
    typedef struct packed {
        logic             has_rpc;
        logic [PC_W-1:0]  rpc;
        logic [PC_W-1:0]  npc;
        logic [LANES-1:0] mask;
    } entry_t;

    stk_op_e          op;
    entry_t           top_q;
    entry_t           top_new;
    entry_t           init_ent;
    entry_t           push_lo;
    entry_t           push_hi;
    logic [CNT_W-1:0] count;
    logic [LANES-1:0] taken_eff;
    logic [LANES-1:0] fall_eff;
    logic             diverge;
    logic             all_taken;
    logic             pop_pending;
    logic             room;
    logic             ovf_set;
    logic             ovf_q;

    rstk_branch_eval #(.LANES(LANES)) i_eval (
        .cur_mask_i   (top_q.mask),
        .taken_mask_i (br_taken_mask_i),
        .taken_eff_o  (taken_eff),
        .fall_eff_o   (fall_eff),
        .diverge_o    (diverge),
        .all_taken_o  (all_taken)
    );

    rstk_store #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ENTRY_T(entry_t)) i_store (
        .clk        (clk),
        .op_i       (op),
        .init_ent_i (init_ent),
        .top_new_i  (top_new),
        .push_lo_i  (push_lo),
        .push_hi_i  (push_hi),
        .top_o      (top_q),
        .count_o    (count)
    );

    assign pop_pending = top_q.has_rpc && (top_q.npc == top_q.rpc);
    assign room        = count <= CNT_W'(DEPTH - 2);

    always_comb begin
        init_ent.has_rpc = 1'b0;
        init_ent.rpc     = '0;
        init_ent.npc     = rst ? RESET_PC : launch_pc_i;
        init_ent.mask    = '1;

        push_lo.has_rpc  = 1'b1;
        push_lo.rpc      = br_reconv_pc_i;
        push_lo.npc      = br_fall_pc_i;
        push_lo.mask     = fall_eff;

        push_hi.has_rpc  = 1'b1;
        push_hi.rpc      = br_reconv_pc_i;
        push_hi.npc      = br_target_pc_i;
        push_hi.mask     = taken_eff;
    end

    always_comb begin
        op      = STK_HOLD;
        top_new = top_q;
        ovf_set = 1'b0;
        if (rst || launch_i) begin
            op = STK_INIT;
        end else if (pop_pending) begin
            op = STK_POP;
        end else if (br_valid_i) begin
            if (diverge) begin
                if (room) begin
                    op          = STK_SPLIT;
                    top_new.npc = br_reconv_pc_i;
                end else begin
                    ovf_set = 1'b1;
                end
            end else begin
                op          = STK_RETARGET;
                top_new.npc = all_taken ? br_target_pc_i : br_fall_pc_i;
            end
        end else if (issue_adv_i) begin
            op          = STK_RETARGET;
            top_new.npc = top_q.npc + PC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || launch_i) begin
            ovf_q <= 1'b0;
        end else if (ovf_set) begin
            ovf_q <= 1'b1;
        end
    end

    assign pc_o       = top_q.npc;
    assign mask_o     = top_q.mask;
    assign ready_o    = !pop_pending;
    assign depth_o    = count;
    assign overflow_o = ovf_q;
endmodule

// File: rtl/reconv_stack_chk.sv
module reconv_stack_chk #(
    parameter int LANES = 4,
    parameter int PC_W  = 16,
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             launch_i,
    input logic [PC_W-1:0]  launch_pc_i,
    input logic             issue_adv_i,
    input logic             br_valid_i,
    input logic [LANES-1:0] br_taken_mask_i,
    input logic [PC_W-1:0]  br_target_pc_i,
    input logic [PC_W-1:0]  br_fall_pc_i,
    input logic [PC_W-1:0]  br_reconv_pc_i,
    input logic [PC_W-1:0]  pc_o,
    input logic [LANES-1:0] mask_o,
    input logic             ready_o,
    input logic [CNT_W-1:0] depth_o,
    input logic             overflow_o
);
    logic [LANES-1:0] eff;
    logic             div;
    logic             act;

    assign eff = br_taken_mask_i & mask_o;
    assign div = (eff != '0) && (eff != mask_o);
    assign act = ready_o && !launch_i;

    assert_launch_R1: assert property (@(posedge clk) disable iff (rst)
        launch_i |=> (depth_o == CNT_W'(1)) && (mask_o == '1) &&
                     (pc_o == $past(launch_pc_i)) && !overflow_o && ready_o);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (act && br_valid_i && div && depth_o > CNT_W'(DEPTH - 2))
            |=> overflow_o && $stable(depth_o) && $stable(pc_o));

    assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (overflow_o && !launch_i) |=> overflow_o);

    assert_split_push_R4: assert property (@(posedge clk) disable iff (rst)
        (act && br_valid_i && div && depth_o <= CNT_W'(DEPTH - 2))
            |=> (depth_o == CNT_W'($past(depth_o) + CNT_W'(2))) &&
                (mask_o == $past(eff)) && (pc_o == $past(br_target_pc_i)));

    assert_uniform_R5: assert property (@(posedge clk) disable iff (rst)
        (act && br_valid_i && !div)
            |=> $stable(depth_o) &&
                (pc_o == ($past(eff) == '0 ? $past(br_fall_pc_i) : $past(br_target_pc_i))));

    assert_advance_R6: assert property (@(posedge clk) disable iff (rst)
        (act && issue_adv_i && !br_valid_i)
            |=> (pc_o == PC_W'($past(pc_o) + PC_W'(1))) && $stable(depth_o));

    assert_pop_R7: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && !launch_i) |=> depth_o == CNT_W'($past(depth_o) - CNT_W'(1)));

    assert_bounds_R8: assert property (@(posedge clk) disable iff (rst)
        (depth_o >= CNT_W'(1)) && (depth_o <= CNT_W'(DEPTH)));
endmodule

bind reconv_stack reconv_stack_chk #(
    .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) i_chk (
    .clk(clk), .rst(rst), .launch_i(launch_i), .launch_pc_i(launch_pc_i),
    .issue_adv_i(issue_adv_i), .br_valid_i(br_valid_i),
    .br_taken_mask_i(br_taken_mask_i), .br_target_pc_i(br_target_pc_i),
    .br_fall_pc_i(br_fall_pc_i), .br_reconv_pc_i(br_reconv_pc_i),
    .pc_o(pc_o), .mask_o(mask_o), .ready_o(ready_o), .depth_o(depth_o),
    .overflow_o(overflow_o)
);

// File: tb/test_reconv_stack.sv
module test_reconv_stack;
    localparam int LANES = 4;
    localparam int PC_W  = 16;
    localparam int DEPTH = 4;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             launch_i = 1'b0;
    logic [PC_W-1:0]  launch_pc_i = '0;
    logic             issue_adv_i = 1'b0;
    logic             br_valid_i = 1'b0;
    logic [LANES-1:0] br_taken_mask_i = '0;
    logic [PC_W-1:0]  br_target_pc_i = '0;
    logic [PC_W-1:0]  br_fall_pc_i = '0;
    logic [PC_W-1:0]  br_reconv_pc_i = '0;
    logic [PC_W-1:0]  pc_o;
    logic [LANES-1:0] mask_o;
    logic             ready_o;
    logic [CNT_W-1:0] depth_o;
    logic             overflow_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) i_reconv_stack (
        .clk(clk), .rst(rst), .launch_i(launch_i), .launch_pc_i(launch_pc_i),
        .issue_adv_i(issue_adv_i), .br_valid_i(br_valid_i),
        .br_taken_mask_i(br_taken_mask_i), .br_target_pc_i(br_target_pc_i),
        .br_fall_pc_i(br_fall_pc_i), .br_reconv_pc_i(br_reconv_pc_i),
        .pc_o(pc_o), .mask_o(mask_o), .ready_o(ready_o), .depth_o(depth_o),
        .overflow_o(overflow_o)
    );

    // Behavioural reference: a queue of entries, back of queue is the top.
    typedef struct {
        bit has;
        int rpc;
        int npc;
        int mask;
    } ment_t;

    ment_t m_stk[$];
    bit    m_ovf;

    function automatic bit m_pending();
        return m_stk[$].has && (m_stk[$].npc == m_stk[$].rpc);
    endfunction

    task automatic model_step();
        ment_t e;
        int    eff;
        int    cur;
        if (rst || launch_i) begin
            m_stk.delete();
            e.has = 0; e.rpc = 0; e.mask = 15;
            e.npc = rst ? 0 : int'(launch_pc_i);
            m_stk.push_back(e);
            m_ovf = 0;
        end else if (m_pending()) begin
            void'(m_stk.pop_back());
        end else if (br_valid_i) begin
            cur = m_stk[$].mask;
            eff = int'(br_taken_mask_i) & cur;
            if (eff != 0 && eff != cur) begin
                if (m_stk.size() + 2 > DEPTH) begin
                    m_ovf = 1;
                end else begin
                    m_stk[$].npc = int'(br_reconv_pc_i);
                    e.has = 1; e.rpc = int'(br_reconv_pc_i);
                    e.npc = int'(br_fall_pc_i); e.mask = cur & ~eff & 15;
                    m_stk.push_back(e);
                    e.npc = int'(br_target_pc_i); e.mask = eff;
                    m_stk.push_back(e);
                end
            end else begin
                m_stk[$].npc = (eff == 0) ? int'(br_fall_pc_i) : int'(br_target_pc_i);
            end
        end else if (issue_adv_i) begin
            m_stk[$].npc = (m_stk[$].npc + 1) & 16'hFFFF;
        end
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic compare_model();
        chk("R2 pc vs model", int'(pc_o), m_stk[$].npc);
        chk("R2 mask vs model", int'(mask_o), m_stk[$].mask);
        chk("R7 depth vs model", int'(depth_o), m_stk.size());
        chk("R7 ready vs model", int'(ready_o), int'(!m_pending()));
        chk("R3 overflow vs model", int'(overflow_o), int'(m_ovf));
    endtask

    // Apply inputs for one clock, advance the model, sample at the next falling edge.
    task automatic cyc(input bit r, input bit l, input int lpc, input bit adv,
                       input bit br, input int tk, input int tg, input int fl, input int rc);
        rst = r; launch_i = l; launch_pc_i = PC_W'(lpc); issue_adv_i = adv;
        br_valid_i = br; br_taken_mask_i = LANES'(tk); br_target_pc_i = PC_W'(tg);
        br_fall_pc_i = PC_W'(fl); br_reconv_pc_i = PC_W'(rc);
        model_step();
        @(negedge clk);
        compare_model();
    endtask

    task automatic idle();          cyc(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic adv(input int n); for (int k = 0; k < n; k++) cyc(0, 0, 0, 1, 0, 0, 0, 0, 0); endtask
    task automatic branch(input int tk, input int tg, input int fl, input int rc);
        cyc(0, 0, 0, 0, 1, tk, tg, fl, rc);
    endtask

    initial begin
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R1 reset pc", int'(pc_o), 0);
        chk("R1 reset mask", int'(mask_o), 15);
        chk("R1 reset depth", int'(depth_o), 1);
        chk("R1 reset overflow", int'(overflow_o), 0);

        adv(3);
        chk("R6 advance", int'(pc_o), 3);

        // Divergent split 1001 / 0110: taken path on top.
        branch(4'b1001, 8, 20, 10);
        chk("R4 split pc", int'(pc_o), 8);
        chk("R4 split mask", int'(mask_o), 9);
        chk("R4 split depth", int'(depth_o), 3);

        adv(2);
        chk("R7 pending ready", int'(ready_o), 0);
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0); // advance ignored during pop
        chk("R7 pop pc", int'(pc_o), 20);
        chk("R7 pop mask", int'(mask_o), 6);
        chk("R7 pop depth", int'(depth_o), 2);

        // Uniform branches inside the 0110 path.
        branch(4'b1111, 5, 77, 99);
        chk("R5 all taken pc", int'(pc_o), 5);
        chk("R5 all taken depth", int'(depth_o), 2);
        branch(4'b1001, 99, 9, 99);
        chk("R8 out-of-mask lanes ignored pc", int'(pc_o), 9);
        chk("R5 none taken depth", int'(depth_o), 2);
        adv(1);
        idle();
        chk("R2 merged pc", int'(pc_o), 10);
        chk("R2 merged mask", int'(mask_o), 15);
        idle();
        chk("R8 base kept", int'(depth_o), 1);
        chk("R8 base ready", int'(ready_o), 1);

        // Overflow with DEPTH = 4.
        branch(4'b0011, 40, 50, 60);
        chk("R4 second split depth", int'(depth_o), 3);
        branch(4'b0001, 41, 45, 46);
        chk("R3 overflow set", int'(overflow_o), 1);
        chk("R3 stack unchanged depth", int'(depth_o), 3);
        chk("R3 stack unchanged pc", int'(pc_o), 40);
        adv(2);
        chk("R3 overflow sticky", int'(overflow_o), 1);

        // Launch, then a split whose fall path is already at reconvergence.
        cyc(0, 1, 100, 0, 0, 0, 0, 0, 0);
        chk("R1 launch pc", int'(pc_o), 100);
        chk("R1 launch mask", int'(mask_o), 15);
        chk("R1 launch overflow", int'(overflow_o), 0);
        branch(4'b1100, 101, 110, 110);
        chk("R4 taken mask", int'(mask_o), 12);
        adv(9);
        chk("R7 taken at reconv", int'(ready_o), 0);
        idle();
        chk("R7 chained pending", int'(ready_o), 0);
        chk("R7 chained depth", int'(depth_o), 2);
        idle();
        chk("R7 chain end depth", int'(depth_o), 1);
        chk("R7 chain end mask", int'(mask_o), 15);
        chk("R7 chain end pc", int'(pc_o), 110);

        // Wrap of the PC counter.
        cyc(0, 1, 16'hFFFF, 0, 0, 0, 0, 0, 0);
        adv(1);
        chk("R6 wrap", int'(pc_o), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule